// File: doc/BRIEF.md
# Buffered Packet FIFO Controller

This block holds the payload bytes of a packet radio working in buffered data mode. In the receive direction, a bit deserializer assembles incoming serial bits into bytes and stores them, and the host reads them out. In the transmit direction, the host writes bytes and a serializer shifts them out. The byte store is a ring of up to 64 entries. A 2-bit length setting picks how much of the ring is in use: 16, 32, 48 or 64 bytes.

Receive filling has two modes. It can be armed by a one-cycle sync-detect strobe from an external start-pattern correlator. It can also be turned on and off directly by a software enable. Transmit serialization also has two start policies: it begins either when the store becomes full or as soon as it holds any byte. After a start, the serializer drains every stored byte. The block reports:

- a not-empty flag;
- a full flag, measured against the selected length;
- a programmable fill-level interrupt for receive;
- a per-byte receive-ready pulse;
- a transmit-done flag;
- a sticky overflow flag.

Top module: `pkt_fifo_ctrl`

## Requirements
- R1: `cfg_len` selects the usable depth: 0 gives 16 bytes, 1 gives 32, 2 gives 48 and 3 gives 64. `fifo_full` is high exactly when the stored count equals that depth.
- R2: While `mode_tx`=0, `thr_irq` is high exactly when the stored count is at least `cfg_thr`+1. While `mode_tx`=1 it is low.
- R3: With `cfg_fill_sw`=0 and `mode_tx`=0, serial bits are ignored until a `sync_det` strobe arms filling. After that, every 8 `bit_tick` cycles form one byte, with the first bit as bit 7, and the byte is stored. Filling stays armed until `mode_tx` or `cfg_fill_sw` is set.
- R4: With `cfg_fill_sw`=1, filling runs exactly while `sw_fill_en`=1, and `sync_det` has no effect.
- R5: With `mode_tx`=1, serialization starts when the store becomes full if `cfg_tx_on_full`=1. If `cfg_tx_on_full`=0, it starts as soon as the store is not empty.
- R6: Once started, the serializer sends each stored byte bit 7 first, one bit per `bit_tick`, with `tx_bit_valid` high. It keeps going until the store is empty.
- R7: `tx_done` rises after the last bit of the last stored byte has been sent. It falls on the next host write.
- R8: `rx_byte_rdy` pulses for one cycle for each received byte that is accepted into the store.
- R9: A host read (`mode_tx`=0) loads the oldest byte into `host_rdata` one cycle later. A read of an empty store leaves `host_rdata` and the flags unchanged. A byte offered to a full store, from either direction, is dropped and sets the sticky `overflow` flag.
- R10: Any change of `cfg_len` empties the store.
- R11: `fifo_not_empty` is high exactly when at least one byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| cfg_len | input | 2 | Usable depth select |
| cfg_thr | input | 6 | Fill-level interrupt threshold minus one |
| cfg_fill_sw | input | 1 | Receive fill control: 0 = sync-armed, 1 = software |
| sw_fill_en | input | 1 | Software receive fill enable |
| cfg_tx_on_full | input | 1 | Transmit start policy: 1 = on full, 0 = on not empty |
| sync_det | input | 1 | One-cycle start-pattern detected strobe |
| bit_tick | input | 1 | Serial bit enable, one bit per high cycle |
| rx_bit | input | 1 | Received serial bit |
| host_wr | input | 1 | Host byte write (transmit direction) |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host byte read (receive direction) |
| host_rdata | output | 8 | Host read data, valid the cycle after a read |
| tx_bit | output | 1 | Transmitted serial bit |
| tx_bit_valid | output | 1 | Serializer is sending |
| fifo_not_empty | output | 1 | Store holds at least one byte |
| fifo_full | output | 1 | Store holds the selected depth |
| thr_irq | output | 1 | Receive fill level reached |
| rx_byte_rdy | output | 1 | Pulse per accepted received byte |
| tx_done | output | 1 | All stored bits sent |
| overflow | output | 1 | Sticky: a byte was dropped at full |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 64-entry ring and a 2-bit length field. This makes the 16- and 32-byte depth settings reachable by filling through the deserializer. With the threshold at 3, the interrupt edge falls between the third and fourth stored byte. A threshold of 63 keeps the interrupt low at a 16-byte depth. Transmit runs with `bit_tick` held high, so a scoreboard can compare every shifted-out byte against the host writes in order. The full-start policy is checked by holding 15 bytes and watching that nothing is sent until the 16th byte arrives.

// File: rtl/pfc_pkg.sv
// Package: shared types for the buffered packet FIFO controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pfc_pkg;
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;
endpackage

// File: rtl/pfc_ring.sv
// Byte ring store with a run-time depth limit.
// Pointers wrap over the physical array. The count never exceeds
// the limit, so a shorter depth needs no extra wrap logic.
// Assumes: the caller flushes when the limit changes.
module pfc_ring #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 64,
    localparam int AW = $clog2(MAX_DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CW-1:0]     depth_lim,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              wr_ok, rd_ok;

    assign full  = (count == depth_lim);
    assign empty = (count == '0);
    assign wr_ok = push && !full && !flush;
    assign rd_ok = pop && !empty && !flush;
    assign head  = mem[rptr];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= push_data;
    end

    // Advance pointers and keep the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(1);
            if (rd_ok) rptr <= rptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R1: outside a flush the count stays within the selected depth.
    assert_count_in_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> count <= depth_lim);
    // R9: a push at full without a pop leaves the count unchanged.
    assert_drop_at_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> count == $past(count));
endmodule

// File: rtl/pfc_rx_deser.sv
// Receive deserializer: gathers serial bits into bytes, first bit as
// MSB. Filling is armed by a sync strobe or gated by a software enable.
// Assumes: bit_tick marks one valid rx_bit per high cycle.
module pfc_rx_deser #(
    parameter int DATA_W = 8,
    localparam int BCW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_on,
    input  logic              sw_mode,
    input  logic              sw_fill,
    input  logic              sync_det,
    input  logic              bit_tick,
    input  logic              bit_in,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data
);
    logic              armed;
    logic              fill;
    logic [BCW-1:0]    bcnt;
    logic [DATA_W-1:0] sh;

    assign fill = rx_on && (sw_mode ? sw_fill : armed);

    // Sync-armed fill latch, dropped when leaving sync-gated receive.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_on || sw_mode) armed <= 1'b0;
        else if (sync_det)               armed <= 1'b1;
    end

    // Shift bits in and emit a byte every DATA_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt      <= '0;
            sh        <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (!fill || (!sw_mode && sync_det)) begin
                bcnt <= '0;
            end else if (bit_tick) begin
                sh <= {sh[DATA_W-2:0], bit_in};
                if (bcnt == BCW'(DATA_W - 1)) begin
                    bcnt      <= '0;
                    byte_vld  <= 1'b1;
                    byte_data <= {sh[DATA_W-2:0], bit_in};
                end else begin
                    bcnt <= bcnt + BCW'(1);
                end
            end
        end
    end

    // R3: nothing is produced outside receive.
    assert_rx_quiet_in_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> !byte_vld);
    // R3: in sync mode, no byte before the strobe arms filling.
    assert_no_fill_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode && !armed) |=> !byte_vld);
    // R4: in software mode, a cleared enable yields no byte.
    assert_sw_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode && !sw_fill) |=> !byte_vld);
endmodule

// File: rtl/pfc_tx_ser.sv
// Transmit serializer: starts by the selected policy, then sends every
// stored byte MSB first, one bit per tick, until the store is empty.
// Assumes: head is valid in the cycle that pop is raised.
module pfc_tx_ser
    import pfc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BW = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_on,
    input  logic              start_on_full,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    input  logic              bit_tick,
    input  logic              host_wr,
    output logic              pop,
    output logic              bit_out,
    output logic              bit_vld,
    output logic              done
);
    ser_state_e        state;
    logic [DATA_W-1:0] sh;
    logic [BW-1:0]     bleft;
    logic              start, last_bit;

    assign start    = tx_on && (state == SER_IDLE) &&
                      (start_on_full ? fifo_full : !fifo_empty);
    assign last_bit = (state == SER_RUN) && bit_tick && (bleft == BW'(1));
    assign pop      = start || (last_bit && !fifo_empty);
    assign bit_out  = sh[DATA_W-1];
    assign bit_vld  = (state == SER_RUN);

    // Serializer state, shift register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_on) begin
            state <= SER_IDLE;
            sh    <= '0;
            bleft <= '0;
        end else if (start) begin
            state <= SER_RUN;
            sh    <= head;
            bleft <= BW'(DATA_W);
        end else if (state == SER_RUN && bit_tick) begin
            if (bleft == BW'(1)) begin
                if (!fifo_empty) begin
                    sh    <= head;
                    bleft <= BW'(DATA_W);
                end else begin
                    state <= SER_IDLE;
                    bleft <= '0;
                end
            end else begin
                sh    <= {sh[DATA_W-2:0], 1'b0};
                bleft <= bleft - BW'(1);
            end
        end
    end

    // Done flag: set when the drain completes, cleared by a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      done <= 1'b0;
        else if (host_wr || start)       done <= 1'b0;
        else if (last_bit && fifo_empty) done <= 1'b1;
    end

    // R7: done is only shown while the serializer is idle.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bit_vld);
    // R5: under the full policy no start happens below full.
    assert_start_policy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_on && start_on_full && !bit_vld && !fifo_full) |=> !bit_vld);
    // R6: a running serializer never pops from an empty store.
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);
endmodule

// File: rtl/pkt_fifo_ctrl.sv
// Buffered packet FIFO controller top. Steers the byte ring between the
// host and the deserializer or serializer, by direction. Derives the
// depth and threshold and produces flags and interrupts.
// Assumes: host writes only matter in transmit and reads in receive.
module pkt_fifo_ctrl #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 64,
    parameter int LEN_W     = 2,
    parameter int THR_W     = 6,
    localparam int AW  = $clog2(MAX_DEPTH),
    localparam int CW  = AW + 1,
    localparam int SEG = MAX_DEPTH >> LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_tx,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic              cfg_fill_sw,
    input  logic              sw_fill_en,
    input  logic              cfg_tx_on_full,
    input  logic              sync_det,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tx_bit,
    output logic              tx_bit_valid,
    output logic              fifo_not_empty,
    output logic              fifo_full,
    output logic              thr_irq,
    output logic              rx_byte_rdy,
    output logic              tx_done,
    output logic              overflow
);
    logic [LEN_W-1:0]  len_q;
    logic              flush;
    logic [CW-1:0]     depth_lim, thr_lvl, count;
    logic              empty;
    logic              rx_vld, tx_pop, push, pop;
    logic [DATA_W-1:0] rx_data, push_data, head;

    assign flush     = (cfg_len != len_q);
    assign depth_lim = CW'((CW'(cfg_len) + CW'(1)) * CW'(SEG));
    assign thr_lvl   = CW'(cfg_thr) + CW'(1);

    assign push      = mode_tx ? host_wr : rx_vld;
    assign push_data = mode_tx ? host_wdata : rx_data;
    assign pop       = mode_tx ? tx_pop : host_rd;

    assign fifo_not_empty = !empty;
    assign thr_irq        = !mode_tx && (count >= thr_lvl);
    assign rx_byte_rdy    = !mode_tx && rx_vld && !fifo_full && !flush;

    // Remember the depth setting so a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= cfg_len;
    end

    // Sticky overflow on a byte offered at full.
    always_ff @(posedge clk) begin
        if (!rst_n)                             overflow <= 1'b0;
        else if (push && fifo_full && !flush)   overflow <= 1'b1;
    end

    // Host read data register, held on an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n)                               host_rdata <= '0;
        else if (!mode_tx && host_rd && !empty)   host_rdata <= head;
    end

    pfc_ring #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth_lim(depth_lim),
        .push(push), .push_data(push_data), .pop(pop), .head(head),
        .count(count), .full(fifo_full), .empty(empty)
    );

    pfc_rx_deser #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_on(!mode_tx), .sw_mode(cfg_fill_sw),
        .sw_fill(sw_fill_en), .sync_det(sync_det), .bit_tick(bit_tick),
        .bit_in(rx_bit), .byte_vld(rx_vld), .byte_data(rx_data)
    );

    pfc_tx_ser #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_on(mode_tx),
        .start_on_full(cfg_tx_on_full), .fifo_full(fifo_full),
        .fifo_empty(empty), .head(head), .bit_tick(bit_tick),
        .host_wr(host_wr && mode_tx), .pop(tx_pop), .bit_out(tx_bit),
        .bit_vld(tx_bit_valid), .done(tx_done)
    );

    // R9: overflow never clears once set.
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R10: a depth change leaves the store empty.
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fifo_not_empty);
    // R8: the ready pulse appears only in receive.
    assert_rdy_rx_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_rdy |-> !mode_tx);
    // R2: the fill-level interrupt is silent in transmit.
    assert_thr_rx_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_tx |-> !thr_irq);
endmodule

// File: tb/pkt_fifo_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected bytes, and monitors
// compare host reads and serialized bytes against the queues.
module pkt_fifo_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_tx = 1'b0;
    logic [1:0] cfg_len = 2'd0;
    logic [5:0] cfg_thr = 6'd3;
    logic       cfg_fill_sw = 1'b0, sw_fill_en = 1'b0, cfg_tx_on_full = 1'b0;
    logic       sync_det = 1'b0, tick_d = 1'b0, tick_free = 1'b0, rx_bit = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       tx_bit, tx_bit_valid, fifo_not_empty, fifo_full;
    logic       thr_irq, rx_byte_rdy, tx_done, overflow;
    logic       bit_tick;

    int total = 0, bad = 0, rdy_cnt = 0, tx_seen = 0, nb = 0;
    logic [7:0] cap = 8'h00;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    assign bit_tick = tick_d | tick_free;
    always #(CLK_PERIOD / 2) clk = ~clk;

    pkt_fifo_ctrl u_pkt_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .cfg_len(cfg_len),
        .cfg_thr(cfg_thr), .cfg_fill_sw(cfg_fill_sw), .sw_fill_en(sw_fill_en),
        .cfg_tx_on_full(cfg_tx_on_full), .sync_det(sync_det),
        .bit_tick(bit_tick), .rx_bit(rx_bit), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid),
        .fifo_not_empty(fifo_not_empty), .fifo_full(fifo_full),
        .thr_irq(thr_irq), .rx_byte_rdy(rx_byte_rdy), .tx_done(tx_done),
        .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic send_rx(input logic [7:0] b, input bit keep);
        for (int i = 7; i >= 0; i--) begin
            rx_bit = b[i]; tick_d = 1'b1; tick(1);
        end
        tick_d = 1'b0; tick(3);
        if (keep) rxq.push_back(b);
    endtask

    task automatic read_cmp(input string req);
        logic [7:0] e;
        host_rd = 1'b1; tick(1); host_rd = 1'b0;
        e = rxq.pop_front();
        check(host_rdata == e, req, host_rdata, e);
    endtask

    task automatic host_put(input logic [7:0] d);
        host_wdata = d; host_wr = 1'b1; tick(1); host_wr = 1'b0;
        txq.push_back(d);
    endtask

    task automatic wait_seen(input int n);
        for (int k = 0; k < 2000 && tx_seen < n; k++) tick(1);
    endtask

    // Monitor: ready pulses and serialized bytes, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && rx_byte_rdy) rdy_cnt++;
        if (rst_n && bit_tick && tx_bit_valid) begin
            cap = {cap[6:0], tx_bit};
            nb++;
            if (nb == 8) begin
                logic [7:0] e;
                nb = 0;
                e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
                tx_seen++;
                check(cap == e, "R6 serial byte MSB first", cap, e);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0;
        tick(3); rst_n = 1'b1; tick(1);
        check(!fifo_not_empty && !fifo_full && !tx_done && !overflow && !thr_irq,
              "R11 reset flags", fifo_not_empty, 0);

        // R3: bits before the sync strobe are ignored.
        r0 = rdy_cnt;
        send_rx(8'h5A, 1'b0);
        check(!fifo_not_empty, "R3 no fill before sync", fifo_not_empty, 0);
        check(rdy_cnt == r0, "R8 no pulse before sync", rdy_cnt, r0);
        sync_det = 1'b1; tick(1); sync_det = 1'b0;
        send_rx(8'hC3, 1'b1); send_rx(8'h12, 1'b1); send_rx(8'hFE, 1'b1);
        check(!thr_irq, "R2 below threshold at 3", thr_irq, 0);
        send_rx(8'h81, 1'b1);
        check(thr_irq, "R2 at threshold 4", thr_irq, 1);
        send_rx(8'h3C, 1'b1);
        check(rdy_cnt == r0 + 5, "R8 one pulse per byte", rdy_cnt, r0 + 5);
        check(fifo_not_empty, "R11 not empty", fifo_not_empty, 1);
        read_cmp("R3 byte1"); read_cmp("R3 byte2");
        check(!thr_irq, "R2 below threshold after reads", thr_irq, 0);
        read_cmp("R9 byte3"); read_cmp("R9 byte4"); read_cmp("R9 byte5");
        check(!fifo_not_empty, "R11 empty after reads", fifo_not_empty, 0);
        host_rd = 1'b1; tick(1); host_rd = 1'b0;
        check(host_rdata == 8'h3C && !fifo_not_empty, "R9 empty read holds",
              host_rdata, 8'h3C);

        // R4: software fill control.
        cfg_fill_sw = 1'b1; sw_fill_en = 1'b0; tick(1);
        sync_det = 1'b1; tick(1); sync_det = 1'b0;
        send_rx(8'h77, 1'b0);
        check(!fifo_not_empty, "R4 disabled fill ignores sync", fifo_not_empty, 0);
        sw_fill_en = 1'b1; tick(1);
        send_rx(8'hA1, 1'b1); send_rx(8'h0F, 1'b1);
        sw_fill_en = 1'b0; tick(1);
        send_rx(8'h99, 1'b0);
        read_cmp("R4 sw byte1"); read_cmp("R4 sw byte2");
        check(!fifo_not_empty, "R4 stop on enable low", fifo_not_empty, 0);

        // R1 at 16 bytes, then overflow.
        cfg_thr = 6'd63; sw_fill_en = 1'b1; tick(1);
        for (int i = 0; i < 15; i++) send_rx(8'(i), 1'b0);
        check(!fifo_full, "R1 not full at 15 of 16", fifo_full, 0);
        send_rx(8'h10, 1'b0);
        check(fifo_full, "R1 full at 16", fifo_full, 1);
        check(!thr_irq, "R2 threshold 64 not reached", thr_irq, 0);
        r0 = rdy_cnt;
        send_rx(8'h11, 1'b0);
        check(overflow && fifo_full, "R9 overflow on full", overflow, 1);
        check(rdy_cnt == r0, "R8 no pulse on dropped byte", rdy_cnt, r0);

        // R10 flush on depth change, then R1 at 32 bytes.
        cfg_len = 2'd1; tick(2);
        check(!fifo_not_empty && !fifo_full, "R10 flush on length change",
              fifo_not_empty, 0);
        for (int i = 0; i < 31; i++) send_rx(8'(i), 1'b0);
        check(!fifo_full, "R1 not full at 31 of 32", fifo_full, 0);
        send_rx(8'h20, 1'b0);
        check(fifo_full, "R1 full at 32", fifo_full, 1);
        check(overflow, "R9 overflow stays set", overflow, 1);
        sw_fill_en = 1'b0;

        // Transmit, not-empty policy.
        cfg_len = 2'd0; tick(2);
        mode_tx = 1'b1; cfg_tx_on_full = 1'b0; tick_free = 1'b1; tick(1);
        check(!thr_irq, "R2 silent in transmit", thr_irq, 0);
        host_put(8'hA5); host_put(8'h3C); host_put(8'hF0);
        wait_seen(3); tick(4);
        check(tx_seen == 3, "R5 start on not empty", tx_seen, 3);
        check(tx_done, "R7 done after drain", tx_done, 1);
        host_put(8'h81);
        check(!tx_done, "R7 done cleared by write", tx_done, 0);
        wait_seen(4); tick(4);

        // Transmit, full policy.
        cfg_tx_on_full = 1'b1; tick(1);
        r0 = tx_seen;
        for (int i = 0; i < 15; i++) host_put(8'(8'h40 + i));
        tick(40);
        check(tx_seen == r0 && !tx_bit_valid, "R5 held below full", tx_seen, r0);
        check(fifo_not_empty && !fifo_full, "R11 holding 15", fifo_not_empty, 1);
        host_put(8'hEE);
        wait_seen(r0 + 16); tick(4);
        check(tx_seen == r0 + 16, "R6 all bytes drained", tx_seen, r0 + 16);
        check(txq.size() == 0 && tx_done, "R7 done after full drain", txq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule